// File: doc/BRIEF.md
# Serial EEPROM Page Buffer and Address Counter

This block sits between the serial-bus protocol controller of a 64K x 8 EEPROM and its storage array. It keeps the current-address register that reads start from, and a 128-byte page latch that collects the data bytes of a write transaction. The controller sends it single-cycle command strobes: load a word address, accept a data byte, step the address after a read byte, commit the transaction on a stop condition, or discard it when a start condition arrives instead of a stop.

While a write transaction is open, each data byte lands at the current in-page offset, and a per-offset valid mask records which offsets were loaded. Only the low seven address bits advance, so a long write wraps within its page and overwrites earlier bytes. On commit the block walks the valid mask in ascending offset order and emits one array write per clock on a simple address/data/enable port. It then pulses a done strobe and leaves the current address set by the write-length rules. When write protect is high at commit time, the walk is empty.

Top module: `eep_page_buffer`

## Requirements
- R1: While reset is asserted and on leaving it, `curAddr` is 0x0000, `busy` is low and `arrWe` is low.
- R2: A `setAddr` strobe taken while idle makes `curAddr` equal `addrIn` from the next cycle on.
- R3: An idle `rdStep` strobe adds one to the full 16-bit `curAddr`, wrapping 0xFFFF to 0x0000.
- R4: Bytes of one write transaction are placed at consecutive in-page offsets. Only address bits 6..0 advance, wrapping 127 to 0, and every array write of a commit carries the page bits 15..7 of the loaded address.
- R5: When more than 128 bytes are written, a later byte replaces the earlier byte at the same offset, and each offset is written to the array at most once per commit.
- R6: A commit writes exactly the offsets loaded since the address was set, in ascending offset order, one per clock. The first write appears in the cycle after the cycle in which `commitStop` is taken.
- R7: `commitDone` is high for exactly one cycle, the cycle after the last array write. With nothing to write, it is high in the cycle after `commitStop`.
- R8: After a commit of n bytes, with 1 <= n <= 127, `curAddr` holds the page bits of the start address and offset (start offset + n) mod 128. For n >= 128 it equals the start address. A single byte at offset 127 therefore leaves offset 0. A commit of zero bytes leaves the start address.
- R9: If `wp` is high in the cycle `commitStop` is taken, no array write occurs. `commitDone` still pulses, and `curAddr` still follows R8.
- R10: An `abortStart` strobe discards the latched bytes without any array write and leaves `curAddr` at the loaded address. A later commit with no new bytes writes nothing.
- R11: `busy` is high from the cycle after `commitStop` through the `commitDone` cycle. Command strobes given while `busy` is high have no effect on `curAddr` or on what is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset (power-on clear) |
| setAddr | input | 1 | Load word address from `addrIn` and open a write transaction |
| addrIn | input | 16 | Word address to load |
| wrByte | input | 1 | Accept `wrData` into the page latch |
| wrData | input | 8 | Data byte to latch |
| rdStep | input | 1 | Advance current address after a read byte |
| commitStop | input | 1 | Stop condition: commit latched bytes |
| abortStart | input | 1 | Start condition instead of stop: discard latched bytes |
| wp | input | 1 | Write protect, sampled with `commitStop` |
| curAddr | output | 16 | Current address, next read location |
| busy | output | 1 | Commit walk in progress |
| arrWe | output | 1 | Array write enable |
| arrAddr | output | 16 | Array write address |
| arrData | output | 8 | Array write data |
| commitDone | output | 1 | One-cycle pulse at the end of a commit |

## Verification
Address commands and read steps are registered once, so `curAddr` is due at the first falling edge after the strobe's rising edge. Commit writes start at that same falling edge and follow at one per cycle, and `commitDone` comes one cycle after the last write. The bench drives every strobe for one cycle from a falling edge and samples at each following falling edge. In a commit it counts falling edges to confirm that the k-th write and the done pulse land in the cycle the requirements give, and that the walk ends with the expected address.

// File: rtl/eep_buf_pkg.sv
package eep_buf_pkg;

  // One-hot-per-cycle command strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadAddr;
    logic takeByte;
    logic stepRead;
    logic snapCommit;
    logic clearLatch;
    logic popOne;
    logic finishCommit;
  } bufStrobes_t;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_COMMIT = 1'b1
  } bufState_t;

endpackage

// File: rtl/eep_lowest_set.sv
module eep_lowest_set #(
  parameter int WIDTH = 128,
  parameter int IDX_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] vec,
  output logic [IDX_W-1:0] idx,
  output logic             any
);

  // Scan from the top so the lowest set bit is the one that remains
  always_comb begin
    idx = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
    any = |vec;
  end

endmodule

// File: rtl/eep_buf_ctrl.sv
module eep_buf_ctrl
  import eep_buf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        setAddr,
  input  logic        wrByte,
  input  logic        rdStep,
  input  logic        commitStop,
  input  logic        abortStart,
  input  logic        workEmpty,
  output bufStrobes_t stb,
  output logic        busy
);

  bufState_t state, stateNext;

  always_comb begin
    stb       = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        // Fixed priority among simultaneous strobes
        if (setAddr)         stb.loadAddr   = 1'b1;
        else if (wrByte)     stb.takeByte   = 1'b1;
        else if (rdStep)     stb.stepRead   = 1'b1;
        else if (commitStop) begin
          stb.snapCommit = 1'b1;
          stateNext      = ST_COMMIT;
        end
        else if (abortStart) stb.clearLatch = 1'b1;
      end
      ST_COMMIT: begin
        if (!workEmpty) begin
          stb.popOne = 1'b1;
        end else begin
          stb.finishCommit = 1'b1;
          stateNext        = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state == ST_COMMIT);

endmodule

// File: rtl/eep_buf_datapath.sv
module eep_buf_datapath
  import eep_buf_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int PAGE_BITS = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  bufStrobes_t       stb,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wp,
  output logic [ADDR_W-1:0] curAddr,
  output logic              workEmpty,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [DATA_W-1:0] arrData
);

  localparam int PAGE_SIZE = 1 << PAGE_BITS;
  localparam int HI_W      = ADDR_W - PAGE_BITS;
  localparam logic [PAGE_BITS:0] FULL_CNT = (PAGE_BITS + 1)'(PAGE_SIZE);

  logic [DATA_W-1:0]    latchMem [PAGE_SIZE];
  logic [PAGE_SIZE-1:0] validMask;
  logic [PAGE_SIZE-1:0] workMask;
  logic [ADDR_W-1:0]    startAddr;
  logic [ADDR_W-1:0]    wrPtr;
  logic [PAGE_BITS:0]   byteCnt;
  logic [PAGE_BITS-1:0] wrOff;
  logic [PAGE_BITS-1:0] wrOffNext;
  logic [PAGE_BITS-1:0] popIdx;
  logic                 popAny;
  logic [ADDR_W-1:0]    addrAfterWrite;

  assign wrOff     = wrPtr[PAGE_BITS-1:0];
  assign wrOffNext = wrOff + PAGE_BITS'(1);

  // A full page or more returns to the start; otherwise the wrapped pointer
  assign addrAfterWrite = (byteCnt == FULL_CNT) ? startAddr : wrPtr;

  eep_lowest_set #(
    .WIDTH(PAGE_SIZE),
    .IDX_W(PAGE_BITS)
  ) u_pick (
    .vec(workMask),
    .idx(popIdx),
    .any(popAny)
  );

  assign workEmpty = !popAny;
  assign arrAddr   = {startAddr[ADDR_W-1:PAGE_BITS], popIdx};
  assign arrData   = latchMem[popIdx];

  // Page storage: no reset, qualified by the valid mask
  always_ff @(posedge clk) begin
    if (stb.takeByte) latchMem[wrOff] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr   <= '0;
      startAddr <= '0;
      wrPtr     <= '0;
      byteCnt   <= '0;
      validMask <= '0;
      workMask  <= '0;
    end else begin
      if (stb.loadAddr) begin
        curAddr   <= addrIn;
        startAddr <= addrIn;
        wrPtr     <= addrIn;
        byteCnt   <= '0;
        validMask <= '0;
      end
      if (stb.takeByte) begin
        validMask[wrOff] <= 1'b1;
        wrPtr            <= {wrPtr[ADDR_W-1:PAGE_BITS], wrOffNext};
        if (byteCnt != FULL_CNT) byteCnt <= byteCnt + 1'b1;
      end
      if (stb.stepRead) begin
        curAddr <= curAddr + ADDR_W'(1);
      end
      if (stb.snapCommit) begin
        workMask  <= wp ? '0 : validMask;
        curAddr   <= addrAfterWrite;
        validMask <= '0;
        byteCnt   <= '0;
        wrPtr     <= startAddr;
      end
      if (stb.clearLatch) begin
        validMask <= '0;
        byteCnt   <= '0;
        wrPtr     <= startAddr;
      end
      if (stb.popOne) begin
        workMask[popIdx] <= 1'b0;
      end
      if (stb.finishCommit) begin
        workMask <= '0;
      end
    end
  end

  logic [HI_W-1:0] unusedHi;
  assign unusedHi = startAddr[ADDR_W-1:PAGE_BITS];

endmodule

// File: rtl/eep_page_buffer.sv
module eep_page_buffer
  import eep_buf_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int PAGE_BITS = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              setAddr,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              wrByte,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdStep,
  input  logic              commitStop,
  input  logic              abortStart,
  input  logic              wp,
  output logic [ADDR_W-1:0] curAddr,
  output logic              busy,
  output logic              arrWe,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [DATA_W-1:0] arrData,
  output logic              commitDone
);

  bufStrobes_t stb;
  logic        workEmpty;

  eep_buf_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .setAddr   (setAddr),
    .wrByte    (wrByte),
    .rdStep    (rdStep),
    .commitStop(commitStop),
    .abortStart(abortStart),
    .workEmpty (workEmpty),
    .stb       (stb),
    .busy      (busy)
  );

  eep_buf_datapath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .PAGE_BITS(PAGE_BITS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .addrIn   (addrIn),
    .wrData   (wrData),
    .wp       (wp),
    .curAddr  (curAddr),
    .workEmpty(workEmpty),
    .arrAddr  (arrAddr),
    .arrData  (arrData)
  );

  assign arrWe      = stb.popOne;
  assign commitDone = stb.finishCommit;

endmodule

// File: rtl/eep_buf_checker.sv
module eep_buf_checker #(
  parameter int ADDR_W    = 16,
  parameter int PAGE_BITS = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              setAddr,
  input logic              wrByte,
  input logic              rdStep,
  input logic              commitStop,
  input logic              wp,
  input logic [ADDR_W-1:0] curAddr,
  input logic              busy,
  input logic              arrWe,
  input logic [ADDR_W-1:0] arrAddr,
  input logic              commitDone
);

  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |=> (curAddr == '0 && !busy && !arrWe));

  p_step_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && rdStep && !setAddr && !wrByte) |=>
      (curAddr == ADDR_W'($past(curAddr) + ADDR_W'(1))));

  p_same_page_ascending_r4: assert property (@(posedge clk) disable iff (!rstN)
    (arrWe && $past(arrWe)) |->
      ((arrAddr[ADDR_W-1:PAGE_BITS] == $past(arrAddr[ADDR_W-1:PAGE_BITS])) &&
       (arrAddr[PAGE_BITS-1:0] > $past(arrAddr[PAGE_BITS-1:0]))));

  p_write_in_commit_r6: assert property (@(posedge clk) disable iff (!rstN)
    arrWe |-> (busy && !commitDone));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    commitDone |=> (!commitDone && !busy));

  p_protect_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && commitStop && wp && !setAddr && !wrByte && !rdStep) |=>
      (!arrWe && commitDone));

  p_addr_frozen_r11: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(curAddr));

endmodule

bind eep_page_buffer eep_buf_checker #(
  .ADDR_W   (ADDR_W),
  .PAGE_BITS(PAGE_BITS)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .setAddr   (setAddr),
  .wrByte    (wrByte),
  .rdStep    (rdStep),
  .commitStop(commitStop),
  .wp        (wp),
  .curAddr   (curAddr),
  .busy      (busy),
  .arrWe     (arrWe),
  .arrAddr   (arrAddr),
  .commitDone(commitDone)
);

// File: tb/tb_eep_page_buffer.sv
`timescale 1ns/1ps
module tb_eep_page_buffer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        setAddr = 1'b0;
  logic [15:0] addrIn = '0;
  logic        wrByte = 1'b0;
  logic [7:0]  wrData = '0;
  logic        rdStep = 1'b0;
  logic        commitStop = 1'b0;
  logic        abortStart = 1'b0;
  logic        wp = 1'b0;
  logic [15:0] curAddr;
  logic        busy;
  logic        arrWe;
  logic [15:0] arrAddr;
  logic [7:0]  arrData;
  logic        commitDone;

  int checks = 0;
  int failures = 0;
  int cycleCount = 0;

  // Bench model of the requirements
  logic [7:0]  mLatch [128];
  logic        mValid [128];
  logic [15:0] mStart;
  logic [15:0] mPtr;
  int          mCnt;
  logic [15:0] mCur;

  always #2 clk = ~clk;

  eep_page_buffer dut (
    .clk(clk), .rstN(rstN), .setAddr(setAddr), .addrIn(addrIn),
    .wrByte(wrByte), .wrData(wrData), .rdStep(rdStep),
    .commitStop(commitStop), .abortStart(abortStart), .wp(wp),
    .curAddr(curAddr), .busy(busy), .arrWe(arrWe), .arrAddr(arrAddr),
    .arrData(arrData), .commitDone(commitDone)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expAfterWrite(input logic [15:0] start, input int cnt);
    logic [6:0] off;
    off = start[6:0] + 7'(cnt);
    if (cnt >= 128) return start;
    return {start[15:7], off};
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic clearModel();
    for (int i = 0; i < 128; i++) mValid[i] = 1'b0;
    mCnt = 0;
    mPtr = mStart;
  endtask

  task automatic doSetAddr(input logic [15:0] a);
    setAddr = 1'b1; addrIn = a;
    step();
    setAddr = 1'b0;
    mStart = a; mCur = a;
    clearModel();
    chk(curAddr == a, "R2", 32'(curAddr), 32'(a));
  endtask

  task automatic doByte(input logic [7:0] d);
    wrByte = 1'b1; wrData = d;
    step();
    wrByte = 1'b0;
    mLatch[mPtr[6:0]] = d;
    mValid[mPtr[6:0]] = 1'b1;
    mPtr = {mPtr[15:7], 7'(mPtr[6:0] + 7'd1)};
    mCnt++;
  endtask

  task automatic doRead();
    rdStep = 1'b1;
    step();
    rdStep = 1'b0;
    mCur = mCur + 16'd1;
    chk(curAddr == mCur, "R3", 32'(curAddr), 32'(mCur));
  endtask

  task automatic doCommit(input bit wpv, input bit inject);
    int expOff [128];
    int nExp = 0;
    int j = 0;
    int cyc = 0;
    bit seenDone = 0;
    logic [15:0] expCur;
    for (int o = 0; o < 128; o++)
      if (mValid[o] && !wpv) begin expOff[nExp] = o; nExp++; end
    expCur = expAfterWrite(mStart, mCnt);
    commitStop = 1'b1; wp = wpv;
    step();
    commitStop = 1'b0; wp = 1'b0;
    while (!seenDone && cyc < 300) begin
      chk(busy == 1'b1, "R11", 32'(busy), 32'd1);
      if (arrWe) begin
        if (j < nExp) begin
          chk(arrAddr == {mStart[15:7], 7'(expOff[j])}, "R4", 32'(arrAddr),
              32'({mStart[15:7], 7'(expOff[j])}));
          chk(arrData == mLatch[expOff[j]], "R5", 32'(arrData),
              32'(mLatch[expOff[j]]));
        end
        chk(cyc == j && j < nExp, wpv ? "R9" : "R6", 32'(cyc), 32'(j));
        j++;
      end
      if (commitDone) begin
        seenDone = 1;
        chk(cyc == nExp, "R7", 32'(cyc), 32'(nExp));
      end else begin
        if (inject && cyc == 0) begin
          rdStep = 1'b1; setAddr = 1'b1; addrIn = 16'hDEAD;
        end
        step();
        rdStep = 1'b0; setAddr = 1'b0;
        cyc++;
      end
    end
    chk(seenDone, "R7", 32'(seenDone), 32'd1);
    chk(j == nExp, wpv ? "R9" : "R6", 32'(j), 32'(nExp));
    step();
    chk(commitDone == 1'b0 && busy == 1'b0, "R7", 32'({commitDone, busy}), 32'd0);
    chk(curAddr == expCur, inject ? "R11" : "R8", 32'(curAddr), 32'(expCur));
    mCur = expCur;
    mStart = expCur;
    clearModel();
  endtask

  task automatic doAbort();
    abortStart = 1'b1;
    step();
    abortStart = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(arrWe == 1'b0, "R10", 32'(arrWe), 32'd0);
      step();
    end
    chk(curAddr == mCur, "R10", 32'(curAddr), 32'(mCur));
    clearModel();
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycleCount++;
    if (cycleCount > 190000) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=<190000", cycleCount);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    mStart = '0; mCur = '0; clearModel();
    for (int i = 0; i < 128; i++) mLatch[i] = '0;

    // R1 reset state
    repeat (3) step();
    chk(curAddr == 16'h0000, "R1", 32'(curAddr), 32'd0);
    chk(busy == 1'b0 && arrWe == 1'b0, "R1", 32'({busy, arrWe}), 32'd0);
    rstN = 1'b1;
    step();
    chk(curAddr == 16'h0000, "R1", 32'(curAddr), 32'd0);

    // R3 steps from zero and across the top of the space
    doRead(); doRead();
    doSetAddr(16'hFFFE);
    doRead(); doRead(); doRead();
    chk(curAddr == 16'h0001, "R3", 32'(curAddr), 32'h1);

    // R8 single byte at offset 127 -> offset 0 of same page
    doSetAddr(16'h12FF);
    doByte(8'hA5);
    doCommit(1'b0, 1'b0);
    chk(curAddr == 16'h1280, "R8", 32'(curAddr), 32'h1280);

    // R8 exactly one page returns to start
    doSetAddr(16'h3405);
    for (int i = 0; i < 128; i++) doByte(8'(i * 3 + 1));
    doCommit(1'b0, 1'b0);
    chk(curAddr == 16'h3405, "R8", 32'(curAddr), 32'h3405);

    // R5 overflow past a page overwrites the first offsets
    doSetAddr(16'h567E);
    for (int i = 0; i < 130; i++) doByte(8'(i ^ 8'h5C));
    doCommit(1'b0, 1'b0);

    // R9 write protect
    doSetAddr(16'h0A10);
    doByte(8'h11); doByte(8'h22); doByte(8'h33);
    doCommit(1'b1, 1'b0);
    chk(curAddr == 16'h0A13, "R9", 32'(curAddr), 32'h0A13);

    // R10 abort then empty commit, then read from loaded address
    doSetAddr(16'h2000);
    for (int i = 0; i < 5; i++) doByte(8'(8'hC0 + i));
    doAbort();
    doCommit(1'b0, 1'b0);
    chk(curAddr == 16'h2000, "R10", 32'(curAddr), 32'h2000);
    doRead();

    // R11 commands during the commit walk are ignored
    doSetAddr(16'h7F7D);
    for (int i = 0; i < 4; i++) doByte(8'(8'h90 + i));
    doCommit(1'b0, 1'b1);

    // Constrained random transactions
    for (int t = 0; t < 40; t++) begin
      int n;
      int kind;
      int nr;
      doSetAddr(16'($urandom));
      n = $urandom_range(0, 135);
      if ($urandom_range(0, 3) == 0) n = $urandom_range(0, 3);
      for (int i = 0; i < n; i++) doByte(8'($urandom));
      kind = $urandom_range(0, 9);
      if (kind < 2) doAbort();
      else doCommit(kind == 2, kind == 3);
      nr = $urandom_range(0, 3);
      for (int r = 0; r < nr; r++) doRead();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule